// File: doc/BRIEF.md
# Pulsed Time-of-Flight Range Controller

This block runs one time-of-flight range measurement at a time. A start request fires a single-cycle emitter pulse. A cycle counter then runs until the echo input reports a return. The block halves the elapsed count and loads it into a registered range output. With a 300 MHz clock, one count of the result equals one metre of target distance. The range output holds its value until the next measurement completes.

Control is a five-state sequencer: start-up clear, idle, fire, count and load. A counter and a halving output register sit beside it. Every register write made in a state lands on the clock edge that leaves that state. Transition decisions therefore see register values from before the write.

The result is a held register with no valid/ready handshake. The consumer may read it at any time and cannot stall the block. There is no back-pressure: a new measurement simply overwrites the previous result.

Top module: `tof_ranger`

## Requirements
- R1: A synchronous active-high reset forces `laser_on` to 0 and `range_out` to 0, including when it arrives in the middle of a measurement.
- R2: After reset is released, the block spends one cycle in a start-up state that ignores `start_btn`. With the button held, `laser_on` first goes high in the second cycle after release.
- R3: `laser_on` is high for exactly one cycle per measurement. That cycle directly follows a cycle in idle with `start_btn` sampled high.
- R4: Let N be the number of counting-state clock edges on which `echo_in` is low, before the first edge with `echo_in` high. `range_out` then becomes floor(N/2). An echo in the first counting cycle gives 0.
- R5: The 16-bit cycle counter wraps modulo 65536 when no echo arrives, and the result is taken from the wrapped count.
- R6: `range_out` changes only on the edge that leaves the load state, which is one cycle after the echo edge. An echo while idle leaves it unchanged and fires no pulse. The old value is held throughout the next measurement.
- R7: `start_btn` pulses during counting have no effect: no extra emitter pulse, and the result is unaffected.
- R8: If `start_btn` is still high when the block returns to idle, a new emitter pulse follows after one idle cycle.
- R9: The counter is cleared in idle before every measurement, so a short measurement after a long one reports only its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Measurement start request, sampled in idle |
| echo_in | input | 1 | Reflection detected |
| laser_on | output | 1 | Emitter enable, one-cycle pulse |
| range_out | output | 16 | Registered half of the elapsed cycle count |

## Verification
The hardest state to reach from the ports is the counter wrap. The echo must stay low for more than 65536 counting cycles. The stimulus therefore holds `echo_in` low for 65541 edges and expects the wrapped result 2. It also runs a 65535-cycle measurement to reach the largest unwrapped result, 32767.

Back-to-back restarts with the button held across the load state are another corner case. So is a reset that lands mid-count. The bench reaches both by timing `start_btn` and `rst` at chosen falling edges relative to the observed emitter pulse.

// File: rtl/tof_pkg.sv
package tof_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_FIRE,
    ST_COUNT,
    ST_LOAD
  } tof_state_e;
endpackage

// File: rtl/tof_ctrl.sv
module tof_ctrl
  import tof_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_btn,
  input  logic       echo_in,
  output tof_state_e state,
  output logic       laser_on,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       rng_clr,
  output logic       rng_load
);
  tof_state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_INIT;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    laser_on = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    rng_clr  = 1'b0;
    rng_load = 1'b0;
    unique case (state)
      ST_INIT: begin
        rng_clr = 1'b1;
        nxt     = ST_IDLE;
      end
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start_btn) nxt = ST_FIRE;
      end
      ST_FIRE: begin
        laser_on = 1'b1;
        nxt      = ST_COUNT;
      end
      ST_COUNT: begin
        if (echo_in) nxt = ST_LOAD;
        else         cnt_inc = 1'b1;
      end
      ST_LOAD: begin
        rng_load = 1'b1;
        nxt      = ST_IDLE;
      end
      default: nxt = ST_INIT;
    endcase
  end
endmodule

// File: rtl/tof_cycle_counter.sv
module tof_cycle_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + ONE;
  end
endmodule

// File: rtl/tof_range_reg.sv
module tof_range_reg #(
  parameter int W     = 16,
  parameter int SHIFT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] scaled;

  generate
    if (SHIFT == 0) begin : g_pass
      assign scaled = din;
    end else begin : g_shift
      assign scaled = din >> SHIFT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= scaled;
  end
endmodule

// File: rtl/tof_ranger.sv
module tof_ranger
  import tof_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HALF  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_btn,
  input  logic             echo_in,
  output logic             laser_on,
  output logic [CNT_W-1:0] range_out
);
  tof_state_e       st;
  logic             cnt_clr, cnt_inc, rng_clr, rng_load;
  logic [CNT_W-1:0] cnt_val;

  tof_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_btn(start_btn),
    .echo_in  (echo_in),
    .state    (st),
    .laser_on (laser_on),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .rng_clr  (rng_clr),
    .rng_load (rng_load)
  );

  tof_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .count(cnt_val)
  );

  tof_range_reg #(.W(CNT_W), .SHIFT(HALF)) u_rng (
    .clk (clk),
    .rst (rst),
    .clr (rng_clr),
    .load(rng_load),
    .din (cnt_val),
    .q   (range_out)
  );
endmodule

// File: rtl/tof_ranger_chk.sv
module tof_ranger_chk
  import tof_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_btn,
  input logic          echo_in,
  input logic          laser_on,
  input logic [CW-1:0] range_out,
  input tof_state_e    st,
  input logic [CW-1:0] cnt
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (range_out == '0 && !laser_on));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    laser_on |=> !laser_on);

  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
    laser_on |-> ($past(st) == ST_IDLE && $past(start_btn)));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && !echo_in) |=> (cnt == CW'($past(cnt) + 1'b1)));

  assert_half_load_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |=> (range_out == ($past(cnt) >> 1)));

  assert_range_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_LOAD) |=> $stable(range_out));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRE) |-> (cnt == '0));
endmodule

bind tof_ranger tof_ranger_chk #(.CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_btn(start_btn),
  .echo_in  (echo_in),
  .laser_on (laser_on),
  .range_out(range_out),
  .st       (st),
  .cnt      (cnt_val)
);

// File: tb/sim_tof_ranger.sv
`timescale 1ns/1ps
module sim_tof_ranger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_btn = 1'b0;
  logic        echo_in = 1'b0;
  logic        laser_on;
  logic [15:0] range_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  tof_ranger u0 (
    .clk      (clk),
    .rst      (rst),
    .start_btn(start_btn),
    .echo_in  (echo_in),
    .laser_on (laser_on),
    .range_out(range_out)
  );

  localparam int NVEC = 8;
  localparam int VEC_N   [NVEC] = '{100, 0, 7, 1, 1001, 2, 255, 3};
  localparam int VEC_EXP [NVEC] = '{50,  0, 3, 0, 500,  1, 127, 1};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Enter at a falling edge with the block idle; returns at a falling edge, idle.
  task automatic measure(input int n, input int exp, input bit poke, input string tag);
    int pulses = 0;
    int prev;
    prev = int'(range_out);
    start_btn = 1'b1;
    @(negedge clk);                       // FIRE
    chk(laser_on == 1'b1, {tag, " R3 pulse"}, int'(laser_on), 1);
    pulses += int'(laser_on);
    start_btn = 1'b0;
    @(negedge clk);                       // COUNT, count 0
    pulses += int'(laser_on);
    for (int i = 0; i < n; i++) begin
      if (poke && i == n / 2) start_btn = 1'b1;
      @(negedge clk);
      start_btn = 1'b0;
      pulses += int'(laser_on);
    end
    chk(int'(range_out) == prev, {tag, " R6 held while counting"}, int'(range_out), prev);
    echo_in = 1'b1;
    @(negedge clk);                       // LOAD
    pulses += int'(laser_on);
    chk(int'(range_out) == prev, {tag, " R6 not before load"}, int'(range_out), prev);
    echo_in = 1'b0;
    @(negedge clk);                       // IDLE, result visible
    pulses += int'(laser_on);
    chk(int'(range_out) == exp, {tag, " R4 result"}, int'(range_out), exp);
    chk(pulses == 1, {tag, " R3 single pulse"}, pulses, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(laser_on == 1'b0, "R1 reset laser", int'(laser_on), 0);
    chk(range_out == 16'd0, "R1 reset range", int'(range_out), 0);

    // R2: button held through reset release
    start_btn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(laser_on == 1'b0, "R2 start-up cycle ignores button", int'(laser_on), 0);
    @(negedge clk);
    chk(laser_on == 1'b1, "R2 pulse second cycle", int'(laser_on), 1);
    start_btn = 1'b0;
    echo_in = 1'b1;
    @(negedge clk);                       // COUNT
    @(negedge clk);                       // LOAD
    echo_in = 1'b0;
    @(negedge clk);
    chk(range_out == 16'd0, "R4 echo first cycle", int'(range_out), 0);

    // Vector table; order mixes long and short runs for R9
    for (int v = 0; v < NVEC; v++)
      measure(VEC_N[v], VEC_EXP[v], 1'b0, "R9 table");

    // R7: button pulse during counting
    measure(40, 20, 1'b1, "R7 button ignored");

    // R6: echo while idle
    for (int i = 0; i < 5; i++) begin
      echo_in = 1'b1;
      @(negedge clk);
      chk(laser_on == 1'b0, "R6 idle echo no pulse", int'(laser_on), 0);
    end
    echo_in = 1'b0;
    chk(range_out == 16'd20, "R6 idle echo keeps range", int'(range_out), 20);

    // R5: largest unwrapped, then wrapped
    measure(65535, 32767, 1'b0, "R5 max");
    measure(65541, 2, 1'b0, "R5 wrap");

    // R8: button still held on return to idle
    start_btn = 1'b1;
    @(negedge clk);                       // FIRE
    @(negedge clk);                       // COUNT
    repeat (9) @(negedge clk);
    echo_in = 1'b1;
    @(negedge clk);                       // LOAD
    echo_in = 1'b0;
    @(negedge clk);                       // IDLE
    chk(range_out == 16'd4, "R8 first result", int'(range_out), 4);
    chk(laser_on == 1'b0, "R8 idle cycle", int'(laser_on), 0);
    @(negedge clk);
    chk(laser_on == 1'b1, "R8 immediate restart", int'(laser_on), 1);
    start_btn = 1'b0;
    @(negedge clk);                       // COUNT
    repeat (6) @(negedge clk);

    // R1: reset mid-count
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(range_out == 16'd0, "R1 mid-count reset range", int'(range_out), 0);
    chk(laser_on == 1'b0, "R1 mid-count reset laser", int'(laser_on), 0);
    rst = 1'b0;
    @(negedge clk);                       // start-up state
    @(negedge clk);                       // idle
    measure(12, 6, 1'b0, "R9 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule